// File: doc/BRIEF.md
# Execute-Stage Redirect Request Generator

This block sits at the end of the execute stage of a multithreaded out-of-order core. Each cycle it receives up to `NCOMP` completing instructions. Slot 0 holds the oldest completion and higher slots hold younger ones. From these it raises at most one squash-and-redirect request per hardware thread, which goes to the front end and to the retirement logic.

A request can have one of three causes:

- **Branch mispredict.** The block squashes everything younger than the branch and steers fetch to the branch's resolved next PC. It also reports the branch's own PC and whether the branch was actually taken.
- **Memory-ordering violation.** The block squashes everything younger than the instruction and steers fetch to its next PC.
- **Load blocked by memory.** This cause counts only while the memory side has not yet reported it as handled. The block squashes the load itself together with everything younger, steers fetch back to the load's own PC, and pulses a handled strobe for that thread.

Per thread, the first completion in slot order that carries a cause wins. Within one completion, the causes are checked in the order listed above. Two wrapping counters record, across all threads, how many mispredict requests came from branches predicted taken and how many came from branches predicted not taken.

Top module: `exec_redirect_gen`

## Requirements
- R1: All request outputs are registered. Completions presented before a clock edge produce their request in the cycle that follows that edge. A thread's request fields are all zero in any cycle without a request for that thread and after reset, so a request lasts exactly one cycle unless a new one arrives.
- R2: For each thread, the request comes from the lowest-numbered slot (slot 0 is oldest) that holds a valid, unsquashed completion of that thread with a cause. Younger completions of that thread are ignored in that cycle.
- R3: A mispredict request carries the branch's sequence number, has the include bit at 0 and the mispredict flag at 1, redirects to the branch's next PC, and reports the branch's PC as the bad PC.
- R4: On a mispredict request, the taken flag is 1 exactly when next PC differs from PC plus `INST_BYTES` (default 4). On any other request the taken flag is 0.
- R5: Within one completion, mispredict takes precedence over an ordering violation, and an ordering violation takes precedence over a blocked load.
- R6: An ordering-violation request carries the instruction's sequence number and redirects to its next PC. Its include bit, mispredict flag, taken flag and bad PC are all 0.
- R7: A blocked load whose thread has `ld_blk_done` at 0 produces a request with the load's sequence number, the include bit at 1, the redirect set to the load's own PC, the mispredict flag at 0 and the bad PC at 0. It also pulses `rq_ld_handled` for that thread. A blocked load whose thread has `ld_blk_done` at 1 is not a cause.
- R8: A completion with `cmp_valid` at 0 or `cmp_squashed` at 1 never produces a request, whatever cause bits it carries.
- R9: For every mispredict request issued, `mis_pt_cnt` increments by one if the branch was predicted taken, and `mis_pnt_cnt` increments by one otherwise. Both counters reset to 0 and wrap.
- R10: Threads are independent. Completions of different threads in the same cycle each produce their own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | NCOMP | Slot holds a completion |
| cmp_squashed | input | NCOMP | Completion already squashed |
| cmp_tid | input | NCOMP x TIDW | Thread of each completion |
| cmp_seq | input | NCOMP x SEQW | Sequence number of each completion |
| cmp_pc | input | NCOMP x PCW | PC of each completion |
| cmp_npc | input | NCOMP x PCW | Resolved next PC of each completion |
| cmp_pred_taken | input | NCOMP | Branch was predicted taken |
| cmp_mispred | input | NCOMP | Branch resolved as mispredicted |
| cmp_ord_viol | input | NCOMP | Memory-ordering violation on this instruction |
| cmp_ld_blocked | input | NCOMP | Load was blocked by memory |
| ld_blk_done | input | NTHREADS | Blocked-load condition already handled for the thread |
| rq_valid | output | NTHREADS | Squash/redirect request |
| rq_seq | output | NTHREADS x SEQW | Squash boundary sequence number |
| rq_incl | output | NTHREADS | Squash includes the boundary instruction |
| rq_target | output | NTHREADS x PCW | Fetch redirect PC |
| rq_bad_pc | output | NTHREADS x PCW | PC of the mispredicted branch |
| rq_taken | output | NTHREADS | Mispredicted branch was actually taken |
| rq_mispred | output | NTHREADS | Request caused by a mispredict |
| rq_ld_handled | output | NTHREADS | Blocked load has been handled (pulse) |
| mis_pt_cnt | output | CNTW | Mispredicts predicted taken |
| mis_pnt_cnt | output | CNTW | Mispredicts predicted not taken |

## Verification
Every request field is recomputed each cycle from that cycle's inputs, so a wrong slot choice or a wrong cause choice shows up within one cycle. It appears on `rq_seq`, `rq_target` or `rq_incl` of the affected thread, in the cycle right after the offending completions. The only state that persists is held in the two counters. A missed or doubled increment stays visible on `mis_pt_cnt` or `mis_pnt_cnt` from the next cycle onward, which is why the reference model compares both counters on every clock.

// File: rtl/exec_redirect_gen.sv
module exec_redirect_gen #(
  parameter int NTHREADS   = 2,
  parameter int NCOMP      = 3,
  parameter int SEQW       = 16,
  parameter int PCW        = 32,
  parameter int INST_BYTES = 4,
  parameter int CNTW       = 16,
  localparam int TIDW      = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NCOMP-1:0]                cmp_valid,
  input  logic [NCOMP-1:0]                cmp_squashed,
  input  logic [NCOMP-1:0][TIDW-1:0]      cmp_tid,
  input  logic [NCOMP-1:0][SEQW-1:0]      cmp_seq,
  input  logic [NCOMP-1:0][PCW-1:0]       cmp_pc,
  input  logic [NCOMP-1:0][PCW-1:0]       cmp_npc,
  input  logic [NCOMP-1:0]                cmp_pred_taken,
  input  logic [NCOMP-1:0]                cmp_mispred,
  input  logic [NCOMP-1:0]                cmp_ord_viol,
  input  logic [NCOMP-1:0]                cmp_ld_blocked,
  input  logic [NTHREADS-1:0]             ld_blk_done,
  output logic [NTHREADS-1:0]             rq_valid,
  output logic [NTHREADS-1:0][SEQW-1:0]   rq_seq,
  output logic [NTHREADS-1:0]             rq_incl,
  output logic [NTHREADS-1:0][PCW-1:0]    rq_target,
  output logic [NTHREADS-1:0][PCW-1:0]    rq_bad_pc,
  output logic [NTHREADS-1:0]             rq_taken,
  output logic [NTHREADS-1:0]             rq_mispred,
  output logic [NTHREADS-1:0]             rq_ld_handled,
  output logic [CNTW-1:0]                 mis_pt_cnt,
  output logic [CNTW-1:0]                 mis_pnt_cnt
);

  logic [NTHREADS-1:0]           claimed;
  logic [NTHREADS-1:0]           n_valid, n_incl, n_taken, n_mispred, n_handled;
  logic [NTHREADS-1:0][SEQW-1:0] n_seq;
  logic [NTHREADS-1:0][PCW-1:0]  n_target, n_bad_pc;
  logic [CNTW-1:0]               n_pt, n_pnt;
  logic [NCOMP-1:0]              live, was_taken;

  for (genvar c = 0; c < NCOMP; c++) begin : g_slot
    assign live[c]      = cmp_valid[c] & ~cmp_squashed[c];
    assign was_taken[c] = cmp_npc[c] != (cmp_pc[c] + PCW'(INST_BYTES));
  end

  always_comb begin
    claimed   = '0;
    n_valid   = '0;
    n_incl    = '0;
    n_taken   = '0;
    n_mispred = '0;
    n_handled = '0;
    n_seq     = '0;
    n_target  = '0;
    n_bad_pc  = '0;
    n_pt      = '0;
    n_pnt     = '0;
    for (int c = 0; c < NCOMP; c++) begin
      for (int t = 0; t < NTHREADS; t++) begin
        if (live[c] && cmp_tid[c] == TIDW'(t) && !claimed[t]) begin
          if (cmp_mispred[c]) begin
            claimed[t]   = 1'b1;
            n_valid[t]   = 1'b1;
            n_mispred[t] = 1'b1;
            n_seq[t]     = cmp_seq[c];
            n_target[t]  = cmp_npc[c];
            n_bad_pc[t]  = cmp_pc[c];
            n_taken[t]   = was_taken[c];
            if (cmp_pred_taken[c]) n_pt  = n_pt + CNTW'(1);
            else                   n_pnt = n_pnt + CNTW'(1);
          end else if (cmp_ord_viol[c]) begin
            claimed[t]  = 1'b1;
            n_valid[t]  = 1'b1;
            n_seq[t]    = cmp_seq[c];
            n_target[t] = cmp_npc[c];
          end else if (cmp_ld_blocked[c] && !ld_blk_done[t]) begin
            claimed[t]   = 1'b1;
            n_valid[t]   = 1'b1;
            n_incl[t]    = 1'b1;
            n_handled[t] = 1'b1;
            n_seq[t]     = cmp_seq[c];
            n_target[t]  = cmp_pc[c];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_valid      <= '0;
      rq_incl       <= '0;
      rq_taken      <= '0;
      rq_mispred    <= '0;
      rq_ld_handled <= '0;
      rq_seq        <= '0;
      rq_target     <= '0;
      rq_bad_pc     <= '0;
      mis_pt_cnt    <= '0;
      mis_pnt_cnt   <= '0;
    end else begin
      rq_valid      <= n_valid;
      rq_incl       <= n_incl;
      rq_taken      <= n_taken;
      rq_mispred    <= n_mispred;
      rq_ld_handled <= n_handled;
      rq_seq        <= n_seq;
      rq_target     <= n_target;
      rq_bad_pc     <= n_bad_pc;
      mis_pt_cnt    <= mis_pt_cnt + n_pt;
      mis_pnt_cnt   <= mis_pnt_cnt + n_pnt;
    end
  end

  AST_DEAD_SLOTS_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((cmp_valid & ~cmp_squashed) == '0) |=> (rq_valid == '0)); // R8

  AST_COUNT_TRACKS_MISPRED: assert property (@(posedge clk) disable iff (rst)
    (CNTW'(mis_pt_cnt + mis_pnt_cnt - $past(mis_pt_cnt) - $past(mis_pnt_cnt))
      == CNTW'($countones(rq_valid & rq_mispred)))); // R9

  for (genvar t = 0; t < NTHREADS; t++) begin : g_chk
    AST_HANDLED_IS_INCL: assert property (@(posedge clk) disable iff (rst)
      rq_ld_handled[t] |-> (rq_valid[t] && rq_incl[t] && !rq_mispred[t])); // R7
    AST_MISPRED_EXCLUDES: assert property (@(posedge clk) disable iff (rst)
      rq_mispred[t] |-> (rq_valid[t] && !rq_incl[t])); // R3
    AST_TAKEN_NEEDS_MISPRED: assert property (@(posedge clk) disable iff (rst)
      rq_taken[t] |-> rq_mispred[t]); // R4
    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rq_valid[t] |-> (rq_seq[t] == '0 && rq_target[t] == '0 && !rq_incl[t])); // R1
  end

endmodule

// File: tb/test_exec_redirect_gen.sv
module test_exec_redirect_gen;
  localparam int NT = 2, NC = 3, SEQW = 16, PCW = 32, CNTW = 16, TIDW = 1;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic [NC-1:0] cmp_valid, cmp_squashed, cmp_pred_taken, cmp_mispred, cmp_ord_viol, cmp_ld_blocked;
  logic [NC-1:0][TIDW-1:0] cmp_tid;
  logic [NC-1:0][SEQW-1:0] cmp_seq;
  logic [NC-1:0][PCW-1:0]  cmp_pc, cmp_npc;
  logic [NT-1:0]           ld_blk_done;
  logic [NT-1:0]           rq_valid, rq_incl, rq_taken, rq_mispred, rq_ld_handled;
  logic [NT-1:0][SEQW-1:0] rq_seq;
  logic [NT-1:0][PCW-1:0]  rq_target, rq_bad_pc;
  logic [CNTW-1:0]         mis_pt_cnt, mis_pnt_cnt;

  exec_redirect_gen i_exec_redirect_gen (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_pt = 0, exp_pnt = 0;
  int e_valid[NT], e_incl[NT], e_taken[NT], e_mis[NT], e_hand[NT];
  longint e_seq[NT], e_tgt[NT], e_bad[NT];

  task automatic chk(string rq, string scen, int t, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) thread %0d: actual=%0h expected=%0h", rq, scen, t, act, exp);
    end
  endtask

  task automatic clear_inputs();
    cmp_valid = '0; cmp_squashed = '0; cmp_pred_taken = '0; cmp_mispred = '0;
    cmp_ord_viol = '0; cmp_ld_blocked = '0; cmp_tid = '0; cmp_seq = '0;
    cmp_pc = '0; cmp_npc = '0; ld_blk_done = '0;
  endtask

  task automatic put(int s, int tid, int seq, longint pc, longint npc, bit ptk, bit mis, bit ov, bit lb);
    cmp_valid[s] = 1; cmp_tid[s] = TIDW'(tid); cmp_seq[s] = SEQW'(seq);
    cmp_pc[s] = PCW'(pc); cmp_npc[s] = PCW'(npc); cmp_pred_taken[s] = ptk;
    cmp_mispred[s] = mis; cmp_ord_viol[s] = ov; cmp_ld_blocked[s] = lb;
  endtask

  // Reference: walk completions oldest-first, keeping a list of threads already served.
  task automatic model();
    int served[$];
    for (int t = 0; t < NT; t++) begin
      e_valid[t] = 0; e_incl[t] = 0; e_taken[t] = 0; e_mis[t] = 0; e_hand[t] = 0;
      e_seq[t] = 0; e_tgt[t] = 0; e_bad[t] = 0;
    end
    for (int s = 0; s < NC; s++) begin
      int t = int'(cmp_tid[s]);
      bit seen = 0;
      foreach (served[k]) if (served[k] == t) seen = 1;
      if (!cmp_valid[s] || cmp_squashed[s] || seen) continue;
      if (cmp_mispred[s]) begin
        served.push_back(t);
        e_valid[t] = 1; e_mis[t] = 1; e_seq[t] = cmp_seq[s];
        e_tgt[t] = cmp_npc[s]; e_bad[t] = cmp_pc[s];
        e_taken[t] = (longint'(cmp_npc[s]) != ((longint'(cmp_pc[s]) + 4) % (64'd1 << PCW))) ? 1 : 0;
        if (cmp_pred_taken[s]) exp_pt++; else exp_pnt++;
      end else if (cmp_ord_viol[s]) begin
        served.push_back(t);
        e_valid[t] = 1; e_seq[t] = cmp_seq[s]; e_tgt[t] = cmp_npc[s];
      end else if (cmp_ld_blocked[s] && !ld_blk_done[t]) begin
        served.push_back(t);
        e_valid[t] = 1; e_incl[t] = 1; e_hand[t] = 1;
        e_seq[t] = cmp_seq[s]; e_tgt[t] = cmp_pc[s];
      end
    end
  endtask

  task automatic compare(string scen);
    for (int t = 0; t < NT; t++) begin
      chk("R1 valid", scen, t, rq_valid[t], e_valid[t]);
      chk("R2 seq", scen, t, rq_seq[t], e_seq[t]);
      chk("R3 mispred", scen, t, rq_mispred[t], e_mis[t]);
      chk("R3 bad_pc", scen, t, rq_bad_pc[t], e_bad[t]);
      chk("R4 taken", scen, t, rq_taken[t], e_taken[t]);
      chk("R6 target", scen, t, rq_target[t], e_tgt[t]);
      chk("R7 incl", scen, t, rq_incl[t], e_incl[t]);
      chk("R7 handled", scen, t, rq_ld_handled[t], e_hand[t]);
    end
    chk("R9 pt_cnt", scen, 0, mis_pt_cnt, exp_pt % (1 << CNTW));
    chk("R9 pnt_cnt", scen, 0, mis_pnt_cnt, exp_pnt % (1 << CNTW));
  endtask

  // Inputs are set mid-cycle; outputs are read 1 ns after the edge that registers them.
  task automatic step(string scen);
    model();
    @(posedge clk); #1;
    compare(scen);
    clear_inputs();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    #1;
    for (int t = 0; t < NT; t++) begin : reset_check
      chk("R1 reset valid", "reset", t, rq_valid[t], 0);
      chk("R1 reset seq", "reset", t, rq_seq[t], 0);
    end
    chk("R9 reset pt", "reset", 0, mis_pt_cnt, 0);
    chk("R9 reset pnt", "reset", 0, mis_pnt_cnt, 0);
    rst = 0;

    put(0, 0, 10, 'h100, 'h200, 0, 1, 0, 0); step("R3 R4 mispredict taken");
    put(0, 1, 11, 'h300, 'h304, 1, 1, 0, 0); step("R4 mispredict not taken");
    step("R1 idle after request");
    put(0, 0, 12, 'h400, 'h404, 0, 0, 1, 0); step("R6 order violation");
    put(0, 1, 13, 'h500, 'h504, 0, 0, 0, 1); step("R7 blocked load");
    put(0, 1, 14, 'h500, 'h504, 0, 0, 0, 1); ld_blk_done = 2'b10; step("R7 blocked load already handled");
    put(0, 0, 20, 'h600, 'h604, 0, 0, 1, 0);
    put(1, 0, 21, 'h610, 'h700, 1, 1, 0, 0); step("R2 oldest wins");
    put(0, 0, 30, 'h800, 'h900, 0, 1, 0, 0); cmp_squashed[0] = 1;
    put(1, 0, 31, 'h810, 'h814, 0, 0, 1, 0); step("R8 squashed skipped");
    put(0, 1, 32, 'hA00, 'hB00, 1, 1, 1, 1); step("R5 mispredict over others");
    put(0, 1, 33, 'hA10, 'hA14, 0, 0, 1, 1); step("R5 order over blocked load");
    put(0, 0, 40, 'hC00, 'hD00, 1, 1, 0, 0);
    put(1, 1, 41, 'hC10, 'hC14, 0, 0, 0, 1);
    put(2, 0, 42, 'hC20, 'hC24, 0, 0, 1, 0); step("R10 threads independent");
    put(2, 1, 50, 'hE00, 'hF00, 0, 1, 1, 1); cmp_valid[2] = 0; step("R8 invalid slot");
    put(0, 0, 60, 'hFFFF_FFFC, 'h0, 0, 1, 0, 0); step("R4 PC wrap not taken");

    for (int i = 0; i < 400; i++) begin
      for (int s = 0; s < NC; s++) begin
        if ($urandom_range(0, 3) != 0) begin
          int pc = int'($urandom_range(0, 255)) * 4;
          put(s, int'($urandom_range(0, NT - 1)), int'($urandom_range(0, 65535)), pc,
              ($urandom_range(0, 1) != 0) ? pc + 4 : pc + 64,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
              1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0));
          cmp_squashed[s] = ($urandom_range(0, 5) == 0);
        end
      end
      ld_blk_done = NT'($urandom_range(0, 3));
      step("R2 R5 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule